// File: doc/BRIEF.md
# Instruction Decode and Step Timing Generator

This block is the front end of the control unit in a small accumulator-style processor. It receives the 16-bit word held in the instruction register. A 3-bit operation field (bits 14..12) is decoded into eight one-hot operation lines. The top bit is passed out as the indirect/mode flag, and the low twelve bits are passed out as the address field.

Alongside the decode, a 4-bit step counter marks the phases of an instruction. The step value is decoded into sixteen one-hot timing lines. A downstream controller steps the counter with an increment command. It clears the counter with a clear command at the end of each instruction, so the next fetch starts at the first timing line.

For test purposes, the block also generates a small set of example control strobes from the operation lines, timing lines, mode flag and low instruction bits: fetch memory read, instruction register load, indirect-address read, and a register-operation selector.

Top module: `ctl_sequencer`

## Requirements
- R1: While the asynchronous active-low reset is held, and after it is released, the step counter is 0, so `t_line` equals 16'h0001.
- R2: On a rising clock edge with `step_inc`=1 and `step_clr`=0, the step value increases by one. With both low, the step value holds.
- R3: At step 15, an increment with no clear returns the step value to 0.
- R4: `step_clr`=1 sets the step value to 0 on the next rising edge, whatever `step_inc` is.
- R5: After reset, exactly one bit of `t_line` is high, and that bit's position equals the step value.
- R6: Exactly one bit of `op_line` is high, at the position given by `instr[14:12]`.
- R7: `mode_bit` equals `instr[15]` and `addr_fld` equals `instr[11:0]`.
- R8: `ir_load` is high only at step 1. At step 1, `mem_rd` is high for every instruction word.
- R9: `ind_rd` is high exactly at step 3 when `instr[14:12]` is not 7 and `instr[15]`=1. `mem_rd` is also high whenever `ind_rd` is high, and `mem_rd` is low at all steps other than 1 and 3.
- R10: At step 3, with `instr[14:12]`=7 and `instr[15]`=0, `reg_op_sel` is a one-hot copy of the lowest set bit of `instr[11:0]`. In every other case, and when the low field is zero, `reg_op_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction register contents |
| step_clr | input | 1 | Synchronous clear of the step counter (dominant) |
| step_inc | input | 1 | Advance the step counter |
| op_line | output | 8 | One-hot operation lines |
| t_line | output | 16 | One-hot timing lines |
| mode_bit | output | 1 | Indirect/mode flag (instr bit 15) |
| addr_fld | output | 12 | Address field (instr bits 11..0) |
| mem_rd | output | 1 | Example memory read strobe |
| ir_load | output | 1 | Example instruction register load strobe |
| ind_rd | output | 1 | Example indirect-address read strobe |
| reg_op_sel | output | 12 | Example register-operation selector |

## Verification
The counter is exercised in three ways:
- A full walk through all sixteen steps, which shows that wrap-around works.
- Idle cycles, which show that the value holds.
- Clear applied at the same time as increment and at a mid-count step, which shows that clear takes priority.

All eight opcodes are applied with the mode bit both low and high. Comparing operation lines and pass-through fields across these words separates a wrong field slice from a wrong decode. Each opcode and mode pair is then held at steps 1, 2 and 3, so that indirect reads and register operations can be told apart from fetch strobes. Low-field patterns with one set bit, several set bits and no set bit show whether the selector picks the lowest bit or merely passes the field through.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

   // Command applied to the step counter on each edge
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_CLR  = 2'd2
   } step_cmd_e;

   // Encode the clear/increment pins; clear dominates
   function automatic step_cmd_e step_cmd(input logic clr, input logic inc);
      if (clr)      return STEP_CLR;
      else if (inc) return STEP_INC;
      else          return STEP_HOLD;
   endfunction

endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter
   import ctl_seq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_cmd_e        cmd,
   output logic [CNT_W-1:0] cnt
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("seq_step_counter: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W:0]   carry;
   logic [CNT_W-1:0] jin, kin, nxt;

   assign carry[0] = (cmd == STEP_INC);

   // Each bit is a J-K stage: toggle on carry, forced low on clear
   for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      assign carry[i+1] = carry[i] & cnt[i];
      assign jin[i]     = (cmd == STEP_CLR) ? 1'b0 : carry[i];
      assign kin[i]     = (cmd == STEP_CLR) ? 1'b1 : carry[i];
      assign nxt[i]     = (jin[i] & ~cnt[i]) | (~kin[i] & cnt[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == STEP_CLR) |=> (cnt == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == STEP_INC) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == STEP_HOLD) |=> $stable(cnt));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == STEP_INC) && (&cnt)) |=> (cnt == '0));

endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
   parameter int SEL_W = 3,
   parameter int OUT_N = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   output logic [OUT_N-1:0] line
);

   generate
      if (OUT_N > (1 << SEL_W) || OUT_N < 1) begin : g_bad_size
         $error("onehot_dec: OUT_N must lie in 1..2**SEL_W");
      end
   endgenerate

   for (genvar i = 0; i < OUT_N; i++) begin : g_line
      assign line[i] = (sel == SEL_W'(i));
   end

endmodule

// File: rtl/lowbit_pick.sv
module lowbit_pick #(
   parameter int VEC_W = 12
) (
   input  logic             en,
   input  logic [VEC_W-1:0] vec,
   output logic [VEC_W-1:0] pick
);

   generate
      if (VEC_W < 1) begin : g_bad_width
         $error("lowbit_pick: VEC_W must be at least 1");
      end
   endgenerate

   logic [VEC_W:0] seen;
   assign seen[0] = 1'b0;

   // Ripple chain: a bit wins only if no lower bit was set
   for (genvar i = 0; i < VEC_W; i++) begin : g_chain
      assign seen[i+1] = seen[i] | vec[i];
      assign pick[i]   = en & vec[i] & ~seen[i];
   end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
   import ctl_seq_pkg::*;
#(
   parameter int INSTR_W  = 16,
   parameter int OP_W     = 3,
   parameter int STEP_W   = 4,
   parameter int FETCH_T  = 1,
   parameter int INDIR_T  = 3,
   parameter int REGOP_OP = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [INSTR_W-1:0]   instr,
   input  logic                 step_clr,
   input  logic                 step_inc,
   output logic [(1<<OP_W)-1:0] op_line,
   output logic [(1<<STEP_W)-1:0] t_line,
   output logic                 mode_bit,
   output logic [INSTR_W-OP_W-2:0] addr_fld,
   output logic                 mem_rd,
   output logic                 ir_load,
   output logic                 ind_rd,
   output logic [INSTR_W-OP_W-2:0] reg_op_sel
);

   localparam int ADDR_W = INSTR_W - OP_W - 1;
   localparam int OPS_N  = 1 << OP_W;
   localparam int STEPS  = 1 << STEP_W;
   localparam int OP_LO  = ADDR_W;
   localparam int MODE_B = INSTR_W - 1;

   generate
      if (ADDR_W < 1) begin : g_bad_split
         $error("ctl_sequencer: instruction too narrow for the opcode");
      end
      if (FETCH_T >= STEPS || INDIR_T >= STEPS) begin : g_bad_step
         $error("ctl_sequencer: strobe steps exceed counter range");
      end
      if (REGOP_OP >= OPS_N) begin : g_bad_op
         $error("ctl_sequencer: register-op opcode out of range");
      end
   endgenerate

   logic [STEP_W-1:0] step_q;
   step_cmd_e         cmd;
   logic              regop_en;

   assign cmd = step_cmd(step_clr, step_inc);

   seq_step_counter #(.CNT_W(STEP_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .cnt   (step_q)
   );

   onehot_dec #(.SEL_W(STEP_W), .OUT_N(STEPS)) u_tdec (
      .sel  (step_q),
      .line (t_line)
   );

   onehot_dec #(.SEL_W(OP_W), .OUT_N(OPS_N)) u_odec (
      .sel  (instr[OP_LO +: OP_W]),
      .line (op_line)
   );

   assign mode_bit = instr[MODE_B];
   assign addr_fld = instr[ADDR_W-1:0];

   // Example control equations
   assign ir_load  = t_line[FETCH_T];
   assign ind_rd   = t_line[INDIR_T] & ~op_line[REGOP_OP] & mode_bit;
   assign mem_rd   = t_line[FETCH_T] | ind_rd;
   assign regop_en = t_line[INDIR_T] & op_line[REGOP_OP] & ~mode_bit;

   lowbit_pick #(.VEC_W(ADDR_W)) u_pick (
      .en   (regop_en),
      .vec  (addr_fld),
      .pick (reg_op_sel)
   );

   assert_tline_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(t_line) == 1);

   assert_opline_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(op_line) == 1);

   assert_indrd_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ind_rd |-> mem_rd);

   assert_regop_pick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_op_sel) && ((reg_op_sel & ~addr_fld) == '0));

   assert_irload_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |-> (mem_rd && !ind_rd));

endmodule

// File: tb/ctl_sequencer_tb.sv
module ctl_sequencer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;
   logic        step_clr = 1'b0;
   logic        step_inc = 1'b0;
   logic [7:0]  op_line;
   logic [15:0] t_line;
   logic        mode_bit;
   logic [11:0] addr_fld;
   logic        mem_rd, ir_load, ind_rd;
   logic [11:0] reg_op_sel;

   int n_run  = 0;
   int n_fail = 0;
   int exp_step = 0;

   always #2 clk = ~clk;

   ctl_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .instr(instr),
      .step_clr(step_clr), .step_inc(step_inc),
      .op_line(op_line), .t_line(t_line), .mode_bit(mode_bit),
      .addr_fld(addr_fld), .mem_rd(mem_rd), .ir_load(ir_load),
      .ind_rd(ind_rd), .reg_op_sel(reg_op_sel)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One edge with given commands; check happens at following negedge
   task automatic step_edge(input logic clr, input logic inc);
      step_clr = clr;
      step_inc = inc;
      @(negedge clk);
      if (clr)      exp_step = 0;
      else if (inc) exp_step = (exp_step + 1) % 16;
      step_clr = 1'b0;
      step_inc = 1'b0;
   endtask

   task automatic goto_step(input int n);
      step_edge(1'b1, 1'b0);
      for (int i = 0; i < n; i++) step_edge(1'b0, 1'b1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(t_line == 16'h0001, "R1 reset", t_line, 16'h0001);
      rst_n = 1'b1;
      @(negedge clk);
      exp_step = 0;
      chk(t_line == 16'h0001, "R1 after release", t_line, 16'h0001);
   endtask

   task automatic t_walk();
      for (int i = 0; i < 16; i++) begin
         step_edge(1'b0, 1'b1);
         chk(t_line == (16'h1 << exp_step), "R2/R5 walk", t_line, 16'h1 << exp_step);
      end
      chk(t_line == 16'h0001, "R3 wrap to 0", t_line, 16'h0001);
   endtask

   task automatic t_hold();
      goto_step(5);
      for (int i = 0; i < 3; i++) step_edge(1'b0, 1'b0);
      chk(t_line == 16'h0020, "R2 hold", t_line, 16'h0020);
   endtask

   task automatic t_clear();
      goto_step(9);
      step_edge(1'b1, 1'b1);
      chk(t_line == 16'h0001, "R4 clear beats inc", t_line, 16'h0001);
      goto_step(15);
      chk(t_line == 16'h8000, "R5 step 15", t_line, 16'h8000);
      step_edge(1'b1, 1'b0);
      chk(t_line == 16'h0001, "R4 clear at 15", t_line, 16'h0001);
   endtask

   task automatic t_decode();
      for (int op = 0; op < 8; op++) begin
         for (int m = 0; m < 2; m++) begin
            instr = {m[0], op[2:0], 12'hA5C ^ 12'(op * 37)};
            #1;
            chk(op_line == (8'h1 << op), "R6 op decode", op_line, 8'h1 << op);
            chk(mode_bit == m[0], "R7 mode bit", mode_bit, m);
            chk(addr_fld == instr[11:0], "R7 addr field", addr_fld, instr[11:0]);
         end
      end
   endtask

   task automatic t_strobes();
      for (int st = 0; st < 5; st++) begin
         goto_step(st);
         for (int op = 0; op < 8; op++) begin
            for (int m = 0; m < 2; m++) begin
               logic e_ind, e_rd, e_ld;
               logic [11:0] e_sel;
               instr = {m[0], op[2:0], 12'b0110_1000_1000};
               #1;
               e_ld  = (st == 1);
               e_ind = (st == 3) && (op != 7) && (m == 1);
               e_rd  = e_ld || e_ind;
               e_sel = ((st == 3) && (op == 7) && (m == 0)) ? 12'h008 : 12'h000;
               chk(ir_load == e_ld, "R8 ir_load", ir_load, e_ld);
               chk(mem_rd == e_rd, "R8/R9 mem_rd", mem_rd, e_rd);
               chk(ind_rd == e_ind, "R9 ind_rd", ind_rd, e_ind);
               chk(reg_op_sel == e_sel, "R10 reg op gating", reg_op_sel, e_sel);
            end
         end
      end
   endtask

   task automatic t_regop();
      logic [11:0] pats [6];
      pats = '{12'h001, 12'h800, 12'hFFF, 12'h000, 12'hA40, 12'h030};
      goto_step(3);
      foreach (pats[k]) begin
         logic [11:0] e;
         e = pats[k] & (~pats[k] + 12'h1);
         instr = {1'b0, 3'd7, pats[k]};
         #1;
         chk(reg_op_sel == e, "R10 lowest bit", reg_op_sel, e);
      end
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_walk();
            t_hold();
            t_clear();
            t_decode();
            t_strobes();
            t_regop();
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule